// File: doc/BRIEF.md
# JTAG Data Register Selector

This block is the data-register half of a JTAG test access port. An external TAP state machine supplies the Capture-DR, Shift-DR and Update-DR strobes, and an external instruction register supplies a 4-bit opcode. From these the block picks one of four scan registers to sit between TDI and TDO: a 32-bit identification register, a boundary-scan chain of parameterised length, a single-bit device-reset register, and a single-bit bypass register.

The boundary-scan chain samples a parallel pin vector on capture. Under the sample/preload opcode, an update copies the chain into a bank of preload latches. These latches are exposed on their own port and never drive the pins. The device-reset bit is special: its value goes straight out as the device reset request, with no update stage, so the request follows the bit while it is being shifted. TDO is taken from the least significant bit of the selected register and is retimed on the falling edge of TCK.

Top module: `jtag_dr_select`

## Requirements
- R1: Opcode 4'h1 selects the identification register, 4'h2 the boundary-scan chain, 4'hC the device-reset bit and 4'hF the bypass bit. Every other opcode selects the bypass bit. When strobes overlap, capture wins over shift, and shift wins over update.
- R2: The selected register shifts on the rising edge of TCK while shift_dr is high. TDI enters at the most significant bit and the register moves toward bit 0. TDO shows bit 0 of the selected register and changes only on the falling edge of TCK.
- R3: Under the identification opcode, a capture loads the ID_VALUE parameter. Shifting then presents it on TDO, bit 0 first.
- R4: While tlr_state is high, the identification register is selected whatever the opcode, and the device-reset bit is cleared on each rising edge.
- R5: Under opcode 4'h2, a capture loads pins_in into the chain, and the value shifts out bit 0 first.
- R6: An update under opcode 4'h2 copies the chain into preload_latch. At every other time, preload_latch holds its value, including during captures and shifts of the chain and updates under other opcodes.
- R7: The device-reset bit changes only by shifting under opcode 4'hC, or by R4/R10. Capture and update have no effect on it. device_reset equals the bit directly, on the same edge on which it changes.
- R8: An asserted device_reset does not disturb the preload latches, and bypass shifting works normally while it is asserted.
- R9: A capture under the bypass opcode loads 0. Shifting then delays TDI by exactly one TCK cycle on the way to TDO.
- R10: Driving trst_n low asynchronously clears tdo, device_reset, preload_latch and the chain, and reloads the identification register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr_state | input | 1 | High while the TAP sits in Test-Logic-Reset |
| ir_code | input | 4 | Current instruction opcode |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| pins_in | input | BS_LEN | Parallel pin values sampled by the chain |
| tdo | output | 1 | Serial data out, falling-edge retimed |
| device_reset | output | 1 | Device reset request, straight from the reset bit |
| preload_latch | output | BS_LEN | Preload latches loaded on update under opcode 4'h2 |

## Verification
The hardest case to reach from the ports is the reset bit being set and then surviving traffic on the other registers. This covers captures and updates under its own opcode, a switch to bypass, and later a return to the preload path. To reach it, the stimulus shifts a single one in under opcode 4'hC. It then strobes capture and update with that opcode still applied, moves to bypass and shifts a pattern while watching device_reset and preload_latch, and finally shifts a zero in to release the request. A separate step pulses tlr_state with the bit set, to show that the clear still happens even though the opcode is left on the reset register.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;

  typedef enum logic [1:0] {
    DR_ID    = 2'd0,
    DR_BSCAN = 2'd1,
    DR_RST   = 2'd2,
    DR_BYP   = 2'd3
  } dr_sel_t;

  localparam logic [3:0] OP_IDCODE  = 4'h1;
  localparam logic [3:0] OP_PRELOAD = 4'h2;
  localparam logic [3:0] OP_DEVRST  = 4'hC;
  localparam logic [3:0] OP_BYPASS  = 4'hF;

  // Opcode to data-register selection; Test-Logic-Reset forces the ID path.
  function automatic dr_sel_t decode_op(input logic [3:0] op, input logic in_tlr);
    if (in_tlr) return DR_ID;
    case (op)
      OP_IDCODE:  return DR_ID;
      OP_PRELOAD: return DR_BSCAN;
      OP_DEVRST:  return DR_RST;
      default:    return DR_BYP;
    endcase
  endfunction

endpackage

// File: rtl/jtag_scan_stage.sv
module jtag_scan_stage #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         clr,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  input  logic         shift_en,
  input  logic         tdi,
  output logic [W-1:0] q
);

  logic [W-1:0] shifted;

  generate
    if (W == 1) begin : g_single
      assign shifted = tdi;
    end else begin : g_multi
      assign shifted = {tdi, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       q <= RST_VAL;
    else if (clr)      q <= RST_VAL;
    else if (cap_en)   q <= cap_val;
    else if (shift_en) q <= shifted;
  end

endmodule

// File: rtl/jtag_preload_bank.sv
module jtag_preload_bank #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         load,
  input  logic [W-1:0] chain,
  output logic [W-1:0] latch_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)   latch_q <= '0;
    else if (load) latch_q <= chain;
  end

endmodule

// File: rtl/jtag_dr_select.sv
module jtag_dr_select
  import jtag_dr_pkg::*;
#(
  parameter int          BS_LEN   = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A2B_3C5D
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tlr_state,
  input  logic [3:0]        ir_code,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic [BS_LEN-1:0] pins_in,
  output logic              tdo,
  output logic              device_reset,
  output logic [BS_LEN-1:0] preload_latch
);

  localparam int ID_W = 32;

  dr_sel_t dr_sel;
  assign dr_sel = decode_op(ir_code, tlr_state);

  // Strobe priority: capture, then shift, then update.
  logic do_cap, do_shift, do_upd;
  assign do_cap   = capture_dr;
  assign do_shift = shift_dr & ~capture_dr;
  assign do_upd   = update_dr & ~capture_dr & ~shift_dr;

  logic sel_id, sel_bs, sel_rst, sel_byp;
  assign sel_id  = (dr_sel == DR_ID);
  assign sel_bs  = (dr_sel == DR_BSCAN);
  assign sel_rst = (dr_sel == DR_RST);
  assign sel_byp = (dr_sel == DR_BYP);

  logic [ID_W-1:0]   id_q;
  logic [BS_LEN-1:0] chain_q;
  logic              rst_q;
  logic              bypass_q;
  logic              bs_update;

  jtag_scan_stage #(.W(ID_W), .RST_VAL(ID_VALUE)) u_id (
    .tck(tck), .trst_n(trst_n), .clr(1'b0),
    .cap_en(do_cap & sel_id), .cap_val(ID_VALUE),
    .shift_en(do_shift & sel_id), .tdi(tdi), .q(id_q)
  );

  jtag_scan_stage #(.W(BS_LEN), .RST_VAL('0)) u_chain (
    .tck(tck), .trst_n(trst_n), .clr(1'b0),
    .cap_en(do_cap & sel_bs), .cap_val(pins_in),
    .shift_en(do_shift & sel_bs), .tdi(tdi), .q(chain_q)
  );

  // Reset bit: no capture action, cleared in Test-Logic-Reset.
  jtag_scan_stage #(.W(1), .RST_VAL(1'b0)) u_rstbit (
    .tck(tck), .trst_n(trst_n), .clr(tlr_state),
    .cap_en(1'b0), .cap_val(1'b0),
    .shift_en(do_shift & sel_rst), .tdi(tdi), .q(rst_q)
  );

  jtag_scan_stage #(.W(1), .RST_VAL(1'b0)) u_bypass (
    .tck(tck), .trst_n(trst_n), .clr(1'b0),
    .cap_en(do_cap & sel_byp), .cap_val(1'b0),
    .shift_en(do_shift & sel_byp), .tdi(tdi), .q(bypass_q)
  );

  assign bs_update = do_upd & sel_bs;

  jtag_preload_bank #(.W(BS_LEN)) u_preload (
    .tck(tck), .trst_n(trst_n), .load(bs_update),
    .chain(chain_q), .latch_q(preload_latch)
  );

  assign device_reset = rst_q;

  logic tdo_src;
  always_comb begin
    case (dr_sel)
      DR_ID:    tdo_src = id_q[0];
      DR_BSCAN: tdo_src = chain_q[0];
      DR_RST:   tdo_src = rst_q;
      default:  tdo_src = bypass_q;
    endcase
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else         tdo <= tdo_src;
  end

endmodule

// File: rtl/jtag_dr_select_chk.sv
module jtag_dr_select_chk
  import jtag_dr_pkg::*;
#(
  parameter int N = 8
) (
  input logic         tck,
  input logic         trst_n,
  input logic         tlr_state,
  input logic         capture_dr,
  input logic         shift_dr,
  input logic         update_dr,
  input logic         tdi,
  input logic [1:0]   sel,
  input logic         bypass_q,
  input logic         device_reset,
  input logic [N-1:0] preload_latch
);

  assert_rstbit_hold_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (!shift_dr && !tlr_state) |=> $stable(device_reset));

  assert_rstbit_shift_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !capture_dr && sel == 2'(DR_RST)) |=> (device_reset == $past(tdi)));

  assert_tlr_clear_R4: assert property (@(posedge tck) disable iff (!trst_n)
    tlr_state |=> !device_reset);

  assert_latch_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
    !(update_dr && !capture_dr && !shift_dr && sel == 2'(DR_BSCAN)) |=> $stable(preload_latch));

  assert_bypass_zero_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && sel == 2'(DR_BYP)) |=> !bypass_q);

endmodule

bind jtag_dr_select jtag_dr_select_chk #(.N(BS_LEN)) u_chk (
  .tck(tck), .trst_n(trst_n), .tlr_state(tlr_state),
  .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
  .tdi(tdi), .sel(dr_sel), .bypass_q(bypass_q),
  .device_reset(device_reset), .preload_latch(preload_latch)
);

// File: tb/jtag_dr_select_bench.sv
`timescale 1ns/1ps
module jtag_dr_select_bench;

  localparam int          N   = 8;
  localparam logic [31:0] IDV = 32'h1A2B_3C5D;

  logic         tck = 1'b0;
  logic         trst_n = 1'b0;
  logic         tlr_state = 1'b0;
  logic [3:0]   ir_code = 4'h1;
  logic         capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic         tdi = 1'b0;
  logic [N-1:0] pins_in = '0;
  logic         tdo, device_reset;
  logic [N-1:0] preload_latch;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 tck = ~tck;

  jtag_dr_select #(.BS_LEN(N), .ID_VALUE(IDV)) u_jtag_dr_select (
    .tck(tck), .trst_n(trst_n), .tlr_state(tlr_state), .ir_code(ir_code),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .pins_in(pins_in), .tdo(tdo), .device_reset(device_reset),
    .preload_latch(preload_latch)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic capture();
    capture_dr = 1'b1; tick(); capture_dr = 1'b0;
  endtask

  task automatic update();
    update_dr = 1'b1; tick(); update_dr = 1'b0;
  endtask

  task automatic shift_n(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1; tdi = din[i];
      dout[i] = tdo;
      tick();
    end
    shift_dr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge tck); #1;
    check("R10 tdo", {63'b0, tdo}, 64'd0);
    check("R10 device_reset", {63'b0, device_reset}, 64'd0);
    check("R10 preload_latch", {56'b0, preload_latch}, 64'd0);
    trst_n = 1'b1;
    tick();
  endtask

  task automatic t_idcode();
    logic [63:0] o;
    ir_code = 4'h1;
    capture();
    shift_n(32, 64'h0, o);
    check("R3 R1 id shift-out", o, {32'b0, IDV});
  endtask

  task automatic t_tdo_edge();
    ir_code = 4'hF;
    capture();
    shift_dr = 1'b1; tdi = 1'b1;
    @(posedge tck); #1;
    check("R2 tdo before falling edge", {63'b0, tdo}, 64'd0);
    @(negedge tck); #1;
    check("R2 tdo after falling edge", {63'b0, tdo}, 64'd1);
    shift_dr = 1'b0;
  endtask

  task automatic t_bypass();
    logic [63:0] o;
    logic [7:0]  d = 8'b1011_0010;
    ir_code = 4'hF;
    check("R9 bypass holds one before capture", {63'b0, tdo}, 64'd1);
    capture();
    check("R9 capture loads zero", {63'b0, tdo}, 64'd0);
    shift_n(8, {56'b0, d}, o);
    check("R9 one-cycle delay", o, {56'b0, d[6:0], 1'b0});
    ir_code = 4'h5;
    capture();
    shift_n(8, {56'b0, ~d}, o);
    check("R1 unknown opcode acts as bypass", o, {56'b0, ~d[6:0], 1'b0});
  endtask

  task automatic t_preload();
    logic [63:0] o;
    ir_code = 4'h2;
    pins_in = 8'hA5;
    capture();
    pins_in = 8'h00;
    shift_n(N, 64'h3C, o);
    check("R5 chain sampled pins", o, 64'hA5);
    check("R6 latch unchanged before update", {56'b0, preload_latch}, 64'd0);
    update();
    check("R6 update copies chain", {56'b0, preload_latch}, 64'h3C);
    pins_in = 8'hFF;
    capture();
    check("R6 capture leaves latch", {56'b0, preload_latch}, 64'h3C);
    ir_code = 4'hF;
    update();
    check("R6 update under bypass ignored", {56'b0, preload_latch}, 64'h3C);
    ir_code = 4'h1;
    update();
    check("R6 update under id ignored", {56'b0, preload_latch}, 64'h3C);
  endtask

  task automatic t_devrst();
    logic [63:0] o;
    ir_code = 4'hC;
    shift_dr = 1'b1; tdi = 1'b1; tick(); shift_dr = 1'b0; tdi = 1'b0;
    check("R7 shifted one drives reset", {63'b0, device_reset}, 64'd1);
    capture();
    check("R7 capture leaves reset bit", {63'b0, device_reset}, 64'd1);
    update();
    check("R7 update leaves reset bit", {63'b0, device_reset}, 64'd1);
    ir_code = 4'hF;
    capture();
    shift_n(4, 64'b1101, o);
    check("R8 bypass works under reset", o, 64'b1010);
    check("R7 reset held after opcode change", {63'b0, device_reset}, 64'd1);
    check("R8 latch kept under reset", {56'b0, preload_latch}, 64'h3C);
    ir_code = 4'hC;
    shift_dr = 1'b1; tdi = 1'b0; tick(); shift_dr = 1'b0;
    check("R7 shifted zero releases reset", {63'b0, device_reset}, 64'd0);
  endtask

  task automatic t_tlr();
    logic [63:0] o;
    ir_code = 4'hC;
    shift_dr = 1'b1; tdi = 1'b1; tick(); shift_dr = 1'b0;
    check("R7 reset bit set again", {63'b0, device_reset}, 64'd1);
    tlr_state = 1'b1;
    tick();
    check("R4 tlr clears reset bit", {63'b0, device_reset}, 64'd0);
    ir_code = 4'hF;
    capture();
    shift_n(32, 64'h0, o);
    check("R4 tlr forces id selection", o, {32'b0, IDV});
    tlr_state = 1'b0;
  endtask

  initial begin
    #1;
    t_reset();
    t_idcode();
    t_tdo_edge();
    t_bypass();
    t_preload();
    t_devrst();
    t_tlr();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule